// File: doc/BRIEF.md
# Contiguous Memory Span Calculator

This block works out how much memory is reachable as one unbroken address range starting at the lowest populated region. Two memory controllers each contribute up to two chip-region descriptors. A descriptor packs a base address in its top byte and an address mask in the byte below it. A controller counts only when its enable flag is set. Its second chip counts only when its chip-count field says an extra chip is fitted. Every descriptor that does not count is replaced by an all-ones word, and that word sorts last.

The four words go through a fixed five-stage compare-exchange network, which puts them in ascending order. Each word is then decoded into a first and last address. The block starts from the length of the lowest region and adds each following region for as long as that region begins exactly one byte past the end of the previous one. It stops at the first break. A request strobe captures the inputs. The result appears in a register together with a single-cycle valid flag. An optional pipeline register after the sort network can be selected by parameter.

Top module: `contig_span_calc`

## Requirements
- R1: A controller is enabled only when bit 0 of its `phy_ctrl` word is 1. A disabled controller contributes neither of its descriptors.
- R2: The second descriptor of an enabled controller is used only when bits [19:16] of its `mem_ctrl` word are non-zero. All other `mem_ctrl` bits have no effect.
- R3: Every descriptor that is not used is treated as 0xFFFFFFFF, and it takes part in the sort and the chaining like any other value.
- R4: The four words are put in ascending unsigned order by compare-exchange on slot pairs (0,2), (1,3), (0,1), (2,3), (1,2), applied in that order. A pair is swapped when its second word is smaller than its first. Slot numbering is controller*2 + chip.
- R5: A region's first address is the descriptor with bits [23:0] cleared. Its last address has bits [31:24] equal to desc[31:24] OR NOT desc[23:16], and bits [23:0] all ones.
- R6: A region's length is last − first + 1, computed modulo 2^32.
- R7: When the lowest sorted word is 0xFFFFFFFF, the reported size is 0.
- R8: The size is the lowest region's length plus, in sorted order, each next region whose first address equals the previous region's last address + 1. Accumulation stops for good at the first region that fails this test.
- R9: The sum is 32 bits wide and wraps modulo 2^32.
- R10: With the default of no sort register, `span_valid` is 1 for exactly the cycle after each `calc_start` pulse, and `span_bytes` updates at that edge. `span_bytes` holds its value until the next strobe, whatever the inputs do in between.
- R11: While `rst_n` is low, `span_valid` is 0 and `span_bytes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| calc_start | input | 1 | One-cycle request strobe that captures the inputs |
| phy_ctrl | input | 2x32 | Per-controller word; bit 0 is the enable flag |
| mem_ctrl | input | 2x32 | Per-controller word; bits [19:16] give the extra-chip count |
| chip_desc | input | 2x2x32 | Region descriptors, indexed [controller][chip] |
| span_valid | output | 1 | Result-valid pulse |
| span_bytes | output | 32 | Length of the contiguous span in bytes |

## Verification
The assertions assume that `calc_start` is never unknown, and that the descriptor and control inputs hold known values on every clock edge once reset is released, because the sort-order property looks at the network output in every cycle. The stimulus keeps to this by driving every input to a defined value from time zero. It changes inputs only at falling edges, with the strobe held high for exactly one cycle. Some directed cases place a region that would chain if it were used next to a disabled controller or an absent second chip. Others place a region after a gap, where it would extend the total if accumulation resumed.

// File: rtl/cspan_pkg.sv
package cspan_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned BASE_LSB = 24;
   localparam int unsigned MASK_LSB = 16;
   localparam int unsigned FIELD_W  = 8;
   localparam int unsigned NET_LEN  = 5;
   localparam int unsigned CNT_LSB  = 16;
   localparam int unsigned CNT_W    = 4;

   typedef logic [WORD_W-1:0] word_t;

   // lower slot of compare-exchange stage k
   function automatic int unsigned net_lo(input int unsigned k);
      case (k)
         0: net_lo = 0;
         1: net_lo = 1;
         2: net_lo = 0;
         3: net_lo = 2;
         default: net_lo = 1;
      endcase
   endfunction

   // upper slot of compare-exchange stage k
   function automatic int unsigned net_hi(input int unsigned k);
      case (k)
         0: net_hi = 2;
         1: net_hi = 3;
         2: net_hi = 1;
         3: net_hi = 3;
         default: net_hi = 2;
      endcase
   endfunction

   function automatic word_t region_first(input word_t d);
      region_first = {d[WORD_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
   endfunction

   function automatic word_t region_last(input word_t d);
      logic [FIELD_W-1:0] top;
      top = d[WORD_W-1:BASE_LSB] | ~d[MASK_LSB+FIELD_W-1:MASK_LSB];
      region_last = {top, {BASE_LSB{1'b1}}};
   endfunction

   function automatic word_t region_size(input word_t d);
      region_size = region_last(d) - region_first(d) + word_t'(1);
   endfunction

endpackage

// File: rtl/cspan_gather.sv
module cspan_gather
   import cspan_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter int unsigned NUM_CTL = 2,
   parameter int unsigned NCHIP   = 2,
   localparam int unsigned NSLOT  = NUM_CTL * NCHIP
) (
   input  logic [NUM_CTL-1:0][DW-1:0]            phy_w,
   input  logic [NUM_CTL-1:0][DW-1:0]            mctl_w,
   input  logic [NUM_CTL-1:0][NCHIP-1:0][DW-1:0] desc_w,
   output logic [NSLOT-1:0][DW-1:0]              slot_o
);

   logic [NUM_CTL-1:0] ctl_on;
   logic [NUM_CTL-1:0] extra_on;

   for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
      assign ctl_on[c]   = phy_w[c][0];
      assign extra_on[c] = |mctl_w[c][CNT_LSB+CNT_W-1:CNT_LSB];

      for (genvar p = 0; p < NCHIP; p++) begin : g_chip
         localparam int unsigned IDX = c * NCHIP + p;
         if (p == 0) begin : g_first
            assign slot_o[IDX] = ctl_on[c] ? desc_w[c][p] : {DW{1'b1}};
         end else begin : g_extra
            assign slot_o[IDX] = (ctl_on[c] && extra_on[c]) ? desc_w[c][p]
                                                             : {DW{1'b1}};
         end
      end
   end

   logic unused_bits;
   always_comb begin
      unused_bits = 1'b0;
      for (int c = 0; c < NUM_CTL; c++) begin
         unused_bits = unused_bits ^ (^phy_w[c][DW-1:1])
                                   ^ (^mctl_w[c][DW-1:CNT_LSB+CNT_W])
                                   ^ (^mctl_w[c][CNT_LSB-1:0]);
      end
   end

endmodule

// File: rtl/cspan_sort4.sv
module cspan_sort4
   import cspan_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned NSLOT = 4
) (
   input  logic [NSLOT-1:0][DW-1:0] in_w,
   output logic [NSLOT-1:0][DW-1:0] out_w
);

   logic [NET_LEN:0][NSLOT-1:0][DW-1:0] stg;

   assign stg[0] = in_w;

   for (genvar k = 0; k < NET_LEN; k++) begin : g_stage
      localparam int unsigned LO = net_lo(k);
      localparam int unsigned HI = net_hi(k);
      logic swap;
      assign swap = stg[k][HI] < stg[k][LO];

      for (genvar j = 0; j < NSLOT; j++) begin : g_lane
         if (j == LO) begin : g_lo
            assign stg[k+1][j] = swap ? stg[k][HI] : stg[k][LO];
         end else if (j == HI) begin : g_hi
            assign stg[k+1][j] = swap ? stg[k][LO] : stg[k][HI];
         end else begin : g_pass
            assign stg[k+1][j] = stg[k][j];
         end
      end
   end

   assign out_w = stg[NET_LEN];

endmodule

// File: rtl/cspan_chain.sv
module cspan_chain
   import cspan_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned NSLOT = 4
) (
   input  logic [NSLOT-1:0][DW-1:0] srt_w,
   output logic [DW-1:0]            total_o
);

   logic [NSLOT-1:0][DW-1:0] first_a;
   logic [NSLOT-1:0][DW-1:0] last_a;
   logic [NSLOT-1:0][DW-1:0] size_a;
   logic [NSLOT-1:0]         link;

   for (genvar i = 0; i < NSLOT; i++) begin : g_dec
      assign first_a[i] = region_first(srt_w[i]);
      assign last_a[i]  = region_last(srt_w[i]);
      assign size_a[i]  = region_size(srt_w[i]);
      if (i == 0) begin : g_head
         assign link[i] = 1'b1;
      end else begin : g_tail
         assign link[i] = first_a[i] == (last_a[i-1] + DW'(1));
      end
   end

   logic          live;
   logic [DW-1:0] acc;

   always_comb begin
      live = 1'b1;
      acc  = size_a[0];
      for (int i = 1; i < NSLOT; i++) begin
         live = live & link[i];
         if (live) begin
            acc = acc + size_a[i];
         end
      end
      if (&srt_w[0]) begin
         acc = '0;
      end
   end

   assign total_o = acc;

endmodule

// File: rtl/contig_span_calc.sv
module contig_span_calc
   import cspan_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned NUM_CTL  = 2,
   parameter int unsigned NCHIP    = 2,
   parameter bit          SORT_REG = 1'b0,
   localparam int unsigned NSLOT   = NUM_CTL * NCHIP
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 calc_start,
   input  logic [NUM_CTL-1:0][DW-1:0]           phy_ctrl,
   input  logic [NUM_CTL-1:0][DW-1:0]           mem_ctrl,
   input  logic [NUM_CTL-1:0][NCHIP-1:0][DW-1:0] chip_desc,
   output logic                                 span_valid,
   output logic [DW-1:0]                        span_bytes
);

   if (DW != WORD_W) begin : g_bad_dw
      $error("contig_span_calc: DW must equal the descriptor width");
   end
   if (NUM_CTL != 2) begin : g_bad_ctl
      $error("contig_span_calc: the sort network needs NUM_CTL == 2");
   end
   if (NCHIP != 2) begin : g_bad_chip
      $error("contig_span_calc: NCHIP must be 2");
   end

   logic [NSLOT-1:0][DW-1:0] slot_w;
   logic [NSLOT-1:0][DW-1:0] srt_w;
   logic [NSLOT-1:0][DW-1:0] head_w;
   logic                     fin_go;
   logic [DW-1:0]            total_w;

   cspan_gather #(.DW(DW), .NUM_CTL(NUM_CTL), .NCHIP(NCHIP)) gather_i (
      .phy_w  (phy_ctrl),
      .mctl_w (mem_ctrl),
      .desc_w (chip_desc),
      .slot_o (slot_w)
   );

   cspan_sort4 #(.DW(DW), .NSLOT(NSLOT)) sort_i (
      .in_w  (slot_w),
      .out_w (srt_w)
   );

   if (SORT_REG) begin : g_sort_pipe
      logic [NSLOT-1:0][DW-1:0] srt_q;
      logic                     go_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            srt_q <= '1;
            go_q  <= 1'b0;
         end else begin
            go_q <= calc_start;
            if (calc_start) begin
               srt_q <= srt_w;
            end
         end
      end
      assign head_w = srt_q;
      assign fin_go = go_q;
   end else begin : g_sort_flat
      assign head_w = srt_w;
      assign fin_go = calc_start;
   end

   cspan_chain #(.DW(DW), .NSLOT(NSLOT)) chain_i (
      .srt_w   (head_w),
      .total_o (total_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         span_valid <= 1'b0;
         span_bytes <= '0;
      end else begin
         span_valid <= fin_go;
         if (fin_go) begin
            span_bytes <= total_w;
         end
      end
   end

endmodule

// File: rtl/cspan_chk.sv
module cspan_chk #(
   parameter int unsigned DW    = 32,
   parameter int unsigned NSLOT = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     fin_go,
   input logic [NSLOT-1:0][DW-1:0] srt,
   input logic [NSLOT-1:0][DW-1:0] head,
   input logic                     valid_o,
   input logic [DW-1:0]            size_o
);

   // R10
   go_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_go |=> valid_o);

   // R10
   idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fin_go |=> !valid_o);

   // R10
   hold_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fin_go |=> $stable(size_o));

   // R4
   sort_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srt[0] <= srt[1]) && (srt[1] <= srt[2]) && (srt[2] <= srt[3]));

   // R7
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_go && (&head[0])) |=> (size_o == '0));

endmodule

bind contig_span_calc cspan_chk #(.DW(DW), .NSLOT(NSLOT)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .fin_go  (fin_go),
   .srt     (srt_w),
   .head    (head_w),
   .valid_o (span_valid),
   .size_o  (span_bytes)
);

// File: tb/contig_span_calc_tb.sv
module contig_span_calc_tb_top;

   localparam int CLK_PERIOD = 10;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 calc_start = 1'b0;
   logic [1:0][31:0]     phy_ctrl = '0;
   logic [1:0][31:0]     mem_ctrl = '0;
   logic [1:0][1:0][31:0] chip_desc = '0;
   logic                 span_valid;
   logic [31:0]          span_bytes;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   contig_span_calc dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .calc_start (calc_start),
      .phy_ctrl   (phy_ctrl),
      .mem_ctrl   (mem_ctrl),
      .chip_desc  (chip_desc),
      .span_valid (span_valid),
      .span_bytes (span_bytes)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic setup(input logic [31:0] p0, input logic [31:0] m0,
                        input logic [31:0] d00, input logic [31:0] d01,
                        input logic [31:0] p1, input logic [31:0] m1,
                        input logic [31:0] d10, input logic [31:0] d11);
      phy_ctrl[0] = p0;  mem_ctrl[0] = m0;
      chip_desc[0][0] = d00; chip_desc[0][1] = d01;
      phy_ctrl[1] = p1;  mem_ctrl[1] = m1;
      chip_desc[1][0] = d10; chip_desc[1][1] = d11;
   endtask

   // strobe at a falling edge, sample valid and size one edge later
   task automatic fire(input string tag, input logic [31:0] exp);
      calc_start = 1'b1;
      @(negedge clk);
      calc_start = 1'b0;
      check(span_valid === 1'b1, {tag, " valid R10"}, {31'd0, span_valid}, 32'd1);
      check(span_bytes === exp, tag, span_bytes, exp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(span_valid === 1'b0, "R11 reset valid", {31'd0, span_valid}, 32'd0);
      check(span_bytes === 32'd0, "R11 reset size", span_bytes, 32'd0);
   endtask

   task automatic t_none();
      @(negedge clk);
      setup(32'h0, 32'h0, 32'h20F80000, 32'h0, 32'h0, 32'h0, 32'h40F80000, 32'h0);
      fire("R7 R1 nothing enabled", 32'h0);
      @(negedge clk);
      setup(32'h1, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
      fire("R7 R3 explicit all-ones descriptor", 32'h0);
   endtask

   task automatic t_single();
      @(negedge clk);
      setup(32'h1, 32'h0, 32'h20F80000, 32'h28F80000, 32'h0, 32'h0, 32'h0, 32'h0);
      fire("R5 R6 single region", 32'h08000000);
   endtask

   task automatic t_adjacent();
      @(negedge clk);
      setup(32'h1, 32'h00010000, 32'h20F80000, 32'h28F80000,
            32'h0, 32'h0, 32'h0, 32'h0);
      fire("R8 two adjacent regions", 32'h10000000);
   endtask

   task automatic t_gap();
      @(negedge clk);
      setup(32'h1, 32'h00010000, 32'h20F80000, 32'h30F80000,
            32'h0, 32'h0, 32'h0, 32'h0);
      fire("R8 gap stops chain", 32'h08000000);
      @(negedge clk);
      setup(32'h1, 32'h00010000, 32'h30F80000, 32'h20F80000,
            32'h1, 32'h0, 32'h38F80000, 32'h0);
      fire("R8 no resume after gap", 32'h08000000);
   endtask

   task automatic t_cross_order();
      @(negedge clk);
      setup(32'h1, 32'h00010000, 32'h50F00000, 32'h40F00000,
            32'h1, 32'h00030000, 32'h30F00000, 32'h60F00000);
      fire("R4 unsorted across controllers", 32'h40000000);
      @(negedge clk);
      setup(32'h1, 32'h00010000, 32'h60F00000, 32'h50F00000,
            32'h1, 32'h00010000, 32'h40F00000, 32'h30F00000);
      fire("R4 reverse order", 32'h40000000);
   endtask

   task automatic t_extra_gate();
      @(negedge clk);
      setup(32'h1, 32'hFFF0FFFF, 32'h20F80000, 32'h28F80000,
            32'h0, 32'h0, 32'h0, 32'h0);
      fire("R2 count field zero ignores chip 1", 32'h08000000);
      @(negedge clk);
      setup(32'h1, 32'h00080000, 32'h20F80000, 32'h28F80000,
            32'h0, 32'h0, 32'h0, 32'h0);
      fire("R2 count field bit 19 enables chip 1", 32'h10000000);
   endtask

   task automatic t_disabled();
      @(negedge clk);
      setup(32'hFFFFFFFE, 32'h00010000, 32'h38F80000, 32'h48F80000,
            32'h1, 32'h0, 32'h40F80000, 32'h0);
      fire("R1 disabled controller ignored", 32'h08000000);
   endtask

   task automatic t_missing_chain();
      @(negedge clk);
      setup(32'h1, 32'h0, 32'hFEFF0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
      fire("R3 filler word chains after FEFFFFFF", 32'h02000000);
   endtask

   task automatic t_wrap();
      @(negedge clk);
      setup(32'h1, 32'h00010000, 32'h00C00000, 32'h40C00000,
            32'h1, 32'h00010000, 32'h80C00000, 32'hC0C00000);
      fire("R9 full space wraps", 32'h00000000);
      @(negedge clk);
      setup(32'h1, 32'h00010000, 32'h00C00000, 32'h40C00000,
            32'h1, 32'h0, 32'h80C00000, 32'h0);
      fire("R9 three quarters", 32'hC0000000);
   endtask

   task automatic t_hold();
      @(negedge clk);
      setup(32'h1, 32'h0, 32'h20F80000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
      fire("R10 setup", 32'h08000000);
      check(span_valid === 1'b1, "R10 valid in pulse cycle", {31'd0, span_valid}, 32'd1);
      @(negedge clk);
      check(span_valid === 1'b0, "R10 single-cycle pulse", {31'd0, span_valid}, 32'd0);
      setup(32'h1, 32'h00010000, 32'h20F80000, 32'h28F80000,
            32'h0, 32'h0, 32'h0, 32'h0);
      repeat (3) @(negedge clk);
      check(span_bytes === 32'h08000000, "R10 holds without strobe",
            span_bytes, 32'h08000000);
      check(span_valid === 1'b0, "R10 no valid without strobe",
            {31'd0, span_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_none();
      t_single();
      t_adjacent();
      t_gap();
      t_cross_order();
      t_extra_gate();
      t_disabled();
      t_missing_chain();
      t_wrap();
      t_hold();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R10 actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule